// File: doc/BRIEF.md
# Serial Port Channel with Divisor Baud Generator

This block is one asynchronous serial channel: a transmitter with a one-byte holding register in front of its shifter, and a receiver with a one-byte buffer. Both run from a 16x oversampling tick. The tick comes from a baud divider that counts either every system clock cycle or every rising edge of a slower external clock. The tick period is (divisor + 1) source periods, so one bit lasts 16 × (divisor + 1) source periods. For example, a 40 MHz source with divisor 21 gives about 115200 baud.

Software controls the channel through a small register port. The port has single-cycle write and read strobes and a combinational read-data path. The frame is always 8 data bits, no parity and one stop bit, sent least significant bit first. Control bits select internal loopback, a forced break on the line, the divider source, and the interrupt modes and types for each direction. Status bits report receive-ready, holding-register-empty, transmitter-fully-idle and framing error. Two interrupt outputs carry the transmit and receive events, either as one-cycle pulses or as levels.

Top module: `uart_chan`

## Requirements
- R1: After reset the status register (address 2) reads 0x0006, the control (address 1) and divisor (address 3) registers read 0, `txd_o` is 1 and both interrupt outputs are 0.
- R2: With control bit 10 clear the divider counts system clock cycles, so one serial bit lasts 16 × (divisor + 1) clock cycles. The divisor register is 16 bits wide.
- R3: A byte written to the holding register (address 4) is sent as one low start bit, then 8 data bits least significant first, then one high stop bit, and the line rests high between frames.
- R4: The receiver accepts a start bit only after 8 consecutive low oversampling ticks. It samples each data bit 16 ticks after the previous sample. On a high stop bit it stores the byte in the receive buffer (address 5, bits 7:0) and sets status bit 0. A low pulse shorter than 8 ticks is ignored.
- R5: A read strobe on address 5 clears status bit 0.
- R6: A write to address 4 clears status bit 1 until the byte moves into the shifter. A second byte written while a frame is in progress waits in the holding register. Status bit 2 is 1 only when the holding register is empty and the shifter is idle.
- R7: With control bit 5 set, the transmit line feeds the receiver internally, `txd_o` stays high and `rxd_i` is ignored.
- R8: With control bit 4 set, the transmit line is driven low for as long as the bit stays set.
- R9: With control bit 10 set, the divider counts rising edges of `ext_clk_i` instead of system clock cycles. Divisor 0 is meant for this source.
- R10: Receive interrupts are enabled when control bits 1:0 equal 01, and transmit interrupts when bits 3:2 equal 01. With bit 8 (receive) or bit 9 (transmit) at 0, the output gives a one-cycle pulse per received byte or per holding-to-shifter move. At 1, it follows receive-ready or holding-empty.
- R11: A low stop bit discards the byte and sets status bit 3. A read strobe on address 2 clears bit 3. With control bit 6 set, a framing error also raises the receive interrupt.
- R12: Address 0 keeps bits 1:0 (the value 3 stands for the 8N1 format, which is the only frame supported). The control and divisor registers read back what was written: 11 and 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the internal divider source |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_clk_i | input | 1 | External divider source, slower than clk |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_rd_i | input | 1 | Read strobe, triggers read side effects |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for the addressed register |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rx_o | output | 1 | Receive interrupt |

## Verification
The bench starts with the sampling corner cases. It sends a low glitch a few ticks too short to be a start bit; a receiver that qualified starts too early would report a bogus byte. It sends a frame with a low stop bit; a receiver that ignored the stop bit would raise receive-ready instead of the framing flag. It writes a second byte while a frame is still shifting; a design with a single register would corrupt the first frame or show the holding register as empty too early. The bench also runs loopback frames with random divisors while it holds `rxd_i` low, runs a divisor of 0 on the external source, and counts interrupt pulses. A pulse that spans more than one cycle, a level that does not drop on the buffer read, or leakage from the pin during loopback each show up as a mismatch.

// File: rtl/uart_chan_pkg.sv
// Shared constants and state types for the serial channel.
// Assumes: 16x oversampling, register addresses fit in 3 bits.
package uart_chan_pkg;
    // register addresses
    localparam logic [2:0] A_LINE = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_DIV  = 3'd3;
    localparam logic [2:0] A_TXH  = 3'd4;
    localparam logic [2:0] A_RXB  = 3'd5;

    // control bit positions
    localparam int CB_ERRIRQ = 6;
    localparam int CB_LOOP   = 5;
    localparam int CB_BRK    = 4;
    localparam int CB_RXTYPE = 8;
    localparam int CB_TXTYPE = 9;
    localparam int CB_SRC    = 10;
    localparam int CTL_W     = CB_SRC + 1;

    // oversampling counter
    localparam int              OS_W    = 4;
    localparam logic [OS_W-1:0] OS_LAST = '1;
    localparam logic [OS_W-1:0] OS_HALF = OS_W'((1 << (OS_W - 1)) - 1);

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_e;
    typedef enum logic [1:0] {RX_IDLE, RX_DATA, RX_STOP} rx_state_e;
endpackage

// File: rtl/uart_chan_baud.sv
// Baud divider: emits one oversampling tick every (div_i + 1) source events.
// A source event is every clk cycle, or a rising edge of ext_clk_i when
// use_ext_i is set. Assumes ext_clk_i is much slower than clk.
module uart_chan_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             use_ext_i,
    input  logic             ext_clk_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    logic [2:0]       ext_sync;
    logic             ext_rise;
    logic             src_en;
    logic             wrap;
    logic [DIV_W-1:0] cnt;

    // bring the external source into the clk domain
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sync <= '0;
        else        ext_sync <= {ext_sync[1:0], ext_clk_i};
    end

    assign ext_rise = ext_sync[1] & ~ext_sync[2];
    assign src_en   = use_ext_i ? ext_rise : 1'b1;
    assign wrap     = (cnt >= div_i);

    // count source events and emit a tick at the wrap point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            tick_o <= 1'b0;
        end else begin
            tick_o <= src_en & wrap;
            if (src_en) cnt <= wrap ? '0 : cnt + 1'b1;
        end
    end

    // back-to-back ticks only when the divisor was zero
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (!tick_o || $past(div_i) == '0));
endmodule

// File: rtl/uart_chan_tx.sv
// Transmitter: holding register feeding a shifter that emits start,
// DATA_W bits LSB first and one stop bit, each 16 ticks long.
// Assumes load_i is a single-cycle strobe; a load while full overwrites.
module uart_chan_tx
    import uart_chan_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              brk_i,
    output logic              line_o,
    output logic              thr_empty_o,
    output logic              idle_o,
    output logic              moved_o
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    tx_state_e         state;
    logic [OS_W-1:0]   tcnt;
    logic [IW-1:0]     idx;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] hold;
    logic              thr_empty;
    logic              move;

    assign move = (state == TX_IDLE) && !thr_empty;

    // holding register and its empty flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold      <= '0;
            thr_empty <= 1'b1;
        end else begin
            if (move) thr_empty <= 1'b1;
            if (load_i) begin
                hold      <= data_i;
                thr_empty <= 1'b0;
            end
        end
    end

    // frame sequencer driven by the oversampling tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TX_IDLE;
            tcnt  <= '0;
            idx   <= '0;
            shreg <= '0;
        end else if (move) begin
            state <= TX_START;
            tcnt  <= '0;
            shreg <= hold;
        end else if (tick_i && state != TX_IDLE) begin
            tcnt <= tcnt + 1'b1;
            if (tcnt == OS_LAST) begin
                case (state)
                    TX_START: begin
                        state <= TX_DATA;
                        idx   <= '0;
                    end
                    TX_DATA: begin
                        shreg <= {1'b0, shreg[DATA_W-1:1]};
                        if (idx == IW'(DATA_W - 1)) state <= TX_STOP;
                        else                         idx   <= idx + 1'b1;
                    end
                    default: state <= TX_IDLE;
                endcase
            end
        end
    end

    // line level for the current frame position, break forces low
    always_comb begin
        if (brk_i)                  line_o = 1'b0;
        else if (state == TX_START) line_o = 1'b0;
        else if (state == TX_DATA)  line_o = shreg[0];
        else                        line_o = 1'b1;
    end

    assign thr_empty_o = thr_empty;
    assign idle_o      = (state == TX_IDLE);
    assign moved_o     = move & ~load_i;

    // a write always leaves the holding register occupied next cycle
    assert_hold_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> !thr_empty_o);
endmodule

// File: rtl/uart_chan_rx.sv
// Receiver: two-flop synchronizer, start qualified by 8 low ticks, then
// one sample every 16 ticks for DATA_W data bits and the stop bit.
// Assumes the line idles high; done_o/ferr_o are single-cycle pulses.
module uart_chan_rx
    import uart_chan_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              rxd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o,
    output logic              ferr_o
);
    localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    logic [1:0]      sync;
    logic            line;
    rx_state_e       state;
    logic [OS_W-1:0] tcnt;
    logic [IW-1:0]   idx;

    // synchronize the serial input
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd_i};
    end
    assign line = sync[1];

    // start qualification, bit sampling and stop check
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            tcnt   <= '0;
            idx    <= '0;
            data_o <= '0;
            done_o <= 1'b0;
            ferr_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            ferr_o <= 1'b0;
            if (tick_i) begin
                case (state)
                    RX_IDLE: begin
                        if (line) tcnt <= '0;
                        else if (tcnt == OS_HALF) begin
                            state <= RX_DATA;
                            tcnt  <= '0;
                            idx   <= '0;
                        end else tcnt <= tcnt + 1'b1;
                    end
                    RX_DATA: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == OS_LAST) begin
                            data_o <= {line, data_o[DATA_W-1:1]};
                            if (idx == IW'(DATA_W - 1)) state <= RX_STOP;
                            else                         idx   <= idx + 1'b1;
                        end
                    end
                    default: begin
                        tcnt <= tcnt + 1'b1;
                        if (tcnt == OS_LAST) begin
                            state  <= RX_IDLE;
                            tcnt   <= '0;
                            done_o <= line;
                            ferr_o <= ~line;
                        end
                    end
                endcase
            end
        end
    end

    // a frame ends at most once, never on two neighbouring cycles
    assert_single_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || ferr_o) |=> !(done_o || ferr_o));
endmodule

// File: rtl/uart_chan.sv
// Serial channel top: register port, control/status, interrupt shaping,
// loopback routing; instantiates the baud divider, transmitter, receiver.
// Assumes single-cycle reg_wr_i/reg_rd_i strobes and DIV_W <= REG_W.
module uart_chan
    import uart_chan_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 8,
    parameter int REG_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic [2:0]       reg_addr_i,
    input  logic             reg_wr_i,
    input  logic             reg_rd_i,
    input  logic [REG_W-1:0] reg_wdata_i,
    output logic [REG_W-1:0] reg_rdata_o,
    input  logic             rxd_i,
    output logic             txd_o,
    output logic             irq_tx_o,
    output logic             irq_rx_o
);
    logic [1:0]        line_q;
    logic [CTL_W-1:0]  ctl_q;
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] rbuf_q;
    logic              rx_rdy_q, ferr_q, rx_pls_q, tx_pls_q;
    logic              tick, tx_line, thr_empty, tx_idle, tx_moved;
    logic [DATA_W-1:0] rx_data;
    logic              rx_done, rx_ferr, rx_in;
    logic              rx_evt, rx_lvl, rx_en, tx_en;
    logic              wr_line, wr_ctl, wr_div, wr_txh, rd_rxb, rd_stat;

    assign wr_line = reg_wr_i && reg_addr_i == A_LINE;
    assign wr_ctl  = reg_wr_i && reg_addr_i == A_CTRL;
    assign wr_div  = reg_wr_i && reg_addr_i == A_DIV;
    assign wr_txh  = reg_wr_i && reg_addr_i == A_TXH;
    assign rd_rxb  = reg_rd_i && reg_addr_i == A_RXB;
    assign rd_stat = reg_rd_i && reg_addr_i == A_STAT;

    uart_chan_baud #(.DIV_W(DIV_W)) baud_i (
        .clk(clk), .rst_n(rst_n), .use_ext_i(ctl_q[CB_SRC]),
        .ext_clk_i(ext_clk_i), .div_i(div_q), .tick_o(tick)
    );

    uart_chan_tx #(.DATA_W(DATA_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .load_i(wr_txh),
        .data_i(reg_wdata_i[DATA_W-1:0]), .brk_i(ctl_q[CB_BRK]),
        .line_o(tx_line), .thr_empty_o(thr_empty), .idle_o(tx_idle),
        .moved_o(tx_moved)
    );

    assign rx_in = ctl_q[CB_LOOP] ? tx_line : rxd_i;
    assign txd_o = ctl_q[CB_LOOP] ? 1'b1 : tx_line;

    uart_chan_rx #(.DATA_W(DATA_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rxd_i(rx_in),
        .data_o(rx_data), .done_o(rx_done), .ferr_o(rx_ferr)
    );

    // software-written configuration
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            ctl_q  <= '0;
            div_q  <= '0;
        end else begin
            if (wr_line) line_q <= reg_wdata_i[1:0];
            if (wr_ctl)  ctl_q  <= reg_wdata_i[CTL_W-1:0];
            if (wr_div)  div_q  <= reg_wdata_i[DIV_W-1:0];
        end
    end

    // receive buffer, ready flag and framing flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rbuf_q   <= '0;
            rx_rdy_q <= 1'b0;
            ferr_q   <= 1'b0;
        end else begin
            if (rx_done) begin
                rbuf_q   <= rx_data;
                rx_rdy_q <= 1'b1;
            end else if (rd_rxb) rx_rdy_q <= 1'b0;
            if (rx_ferr)      ferr_q <= 1'b1;
            else if (rd_stat) ferr_q <= 1'b0;
        end
    end

    assign rx_evt = rx_done | (ctl_q[CB_ERRIRQ] & rx_ferr);
    assign rx_lvl = rx_rdy_q | (ctl_q[CB_ERRIRQ] & ferr_q);
    assign rx_en  = (ctl_q[1:0] == 2'b01);
    assign tx_en  = (ctl_q[3:2] == 2'b01);

    // register the interrupt events into one-cycle pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_pls_q <= 1'b0;
            tx_pls_q <= 1'b0;
        end else begin
            rx_pls_q <= rx_evt;
            tx_pls_q <= tx_moved;
        end
    end

    assign irq_rx_o = rx_en & (ctl_q[CB_RXTYPE] ? rx_lvl : rx_pls_q);
    assign irq_tx_o = tx_en & (ctl_q[CB_TXTYPE] ? thr_empty : tx_pls_q);

    // read data multiplexer
    always_comb begin
        case (reg_addr_i)
            A_LINE:  reg_rdata_o = REG_W'(line_q);
            A_CTRL:  reg_rdata_o = REG_W'(ctl_q);
            A_STAT:  reg_rdata_o = REG_W'({ferr_q, thr_empty & tx_idle,
                                           thr_empty, rx_rdy_q});
            A_DIV:   reg_rdata_o = REG_W'(div_q);
            A_RXB:   reg_rdata_o = REG_W'(rbuf_q);
            default: reg_rdata_o = '0;
        endcase
    end

    // a buffer read with no new byte arriving leaves ready low
    assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rxb && !rx_done) |=> !rx_rdy_q);

    // pulse-type receive interrupt never lasts two cycles
    assert_irq_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx_o && !ctl_q[CB_RXTYPE]) |=> (!irq_rx_o || ctl_q[CB_RXTYPE]));
endmodule

// File: tb/uart_chan_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random loopback.
module uart_chan_tb_top;
    import uart_chan_pkg::*;

    logic        clk = 1'b0, rst_n = 1'b0, ext_clk = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, rxd = 1'b1;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    wire  [15:0] reg_rdata;
    wire         txd, irq_tx, irq_rx;
    int          total = 0, bad = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;
    initial begin #2; forever #35 ext_clk = ~ext_clk; end  // 7-cycle period

    uart_chan dut_i (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk), .reg_addr_i(reg_addr),
        .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .rxd_i(rxd), .txd_o(txd),
        .irq_tx_o(irq_tx), .irq_rx_o(irq_rx)
    );

    function automatic logic [15:0] exp_stat(bit rdy, bit thr, bit all_idle, bit fe);
        return {12'b0, fe, all_idle, thr, rdy};
    endfunction

    function automatic int bit_clks(int dv);
        return 16 * (dv + 1);
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_ok(string req, bit ok, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic peek_now(logic [2:0] a, output logic [15:0] d);
        reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic send_pin(logic [7:0] b, int bp, bit good_stop);
        @(negedge clk); rxd = 1'b0; repeat (bp) @(negedge clk);
        for (int k = 0; k < 8; k++) begin rxd = b[k]; repeat (bp) @(negedge clk); end
        if (good_stop) begin rxd = 1'b1; repeat (bp) @(negedge clk); end
        else begin rxd = 1'b0; repeat (bp * 3 / 4) @(negedge clk); end
        rxd = 1'b1; repeat (bp) @(negedge clk);
    endtask

    task automatic tx_cap(int bp, output logic [7:0] b, output int hi_at, output logic stp);
        int n;
        n = 0; b = '0; hi_at = -1; stp = 1'bx;
        while (txd !== 1'b0 && n < 40000) begin @(negedge clk); n++; end
        for (int c = 0; c <= 9 * bp + bp / 2; c++) begin
            if (hi_at < 0 && txd === 1'b1) hi_at = c;
            if (c >= bp && (c % bp) == bp / 2) begin
                if (c / bp <= 8) b[c / bp - 1] = txd;
                else             stp = txd;
            end
            if (c < 9 * bp + bp / 2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r, s;
        logic [7:0]  b1, b2, exp_b;
        logic        stp;
        int          hi, bp, dv, viol, cnt;
        bit          got, fin;

        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_STAT, r); chk("R1 status", r, exp_stat(0, 1, 1, 0));
        rd(A_CTRL, r); chk("R1 ctrl", r, 0);
        rd(A_DIV, r);  chk("R1 div", r, 0);
        chk("R1 txd", txd, 1);
        chk("R1 irq", {irq_tx, irq_rx}, 0);

        // R12 register readback
        wr(A_LINE, 16'hFFFE); rd(A_LINE, r); chk("R12 line", r, 2);
        wr(A_LINE, 16'h0003); rd(A_LINE, r); chk("R12 line 8N1", r, 3);
        dv = $urandom_range(1, 65535);
        wr(A_DIV, 16'(dv)); rd(A_DIV, r); chk("R12 div", r, dv);
        wr(A_CTRL, 16'hFFFF); rd(A_CTRL, r); chk("R12 ctrl", r, 16'h07FF);
        wr(A_CTRL, 16'h0000);

        // R2 R3 R6 transmit with double buffering
        dv = 2; bp = bit_clks(dv);
        wr(A_DIV, 16'(dv));
        wr(A_TXH, 16'h00A5);
        peek_now(A_STAT, s); chk("R6 write clears empty", s, exp_stat(0, 0, 0, 0));
        fork
            tx_cap(bp, b1, hi, stp);
            begin
                repeat (3 * bp) @(negedge clk);
                wr(A_TXH, 16'h003C);
                peek_now(A_STAT, s); chk("R6 second byte waits", s, exp_stat(0, 0, 0, 0));
                repeat (bp) @(negedge clk);
                peek_now(A_STAT, s); chk("R6 still held", s[1:0], 0);
            end
        join
        chk("R3 first byte", b1, 8'hA5);
        chk("R3 stop high", stp, 1);
        chk_ok("R2 start bit length", hi >= 15 * (dv + 1) && hi <= 16 * (dv + 1) + 1, hi, 16 * (dv + 1));
        tx_cap(bp, b2, hi, stp);
        chk("R3 second byte", b2, 8'h3C);
        repeat (bp) @(negedge clk);
        peek_now(A_STAT, s); chk("R6 all idle", s, exp_stat(0, 1, 1, 0));
        chk("R3 idle high", txd, 1);

        // R4 R5 receive from pin
        dv = 1; bp = bit_clks(dv);
        wr(A_DIV, 16'(dv));
        for (int i = 0; i < 4; i++) begin
            exp_b = 8'($urandom);
            send_pin(exp_b, bp, 1'b1);
            peek_now(A_STAT, s); chk("R4 ready", s[0], 1);
            rd(A_RXB, r); chk("R4 rx byte", r, exp_b);
            peek_now(A_STAT, s); chk("R5 read clears ready", s[0], 0);
        end

        // R4 short low glitch ignored
        @(negedge clk); rxd = 1'b0; repeat (4 * (dv + 1)) @(negedge clk); rxd = 1'b1;
        repeat (2 * bp) @(negedge clk);
        peek_now(A_STAT, s); chk("R4 glitch ignored", s, exp_stat(0, 1, 1, 0));

        // R11 framing error
        send_pin(8'h55, bp, 1'b0);
        peek_now(A_STAT, s); chk("R11 frame error flag", s, exp_stat(0, 1, 1, 1));
        rd(A_STAT, r);
        peek_now(A_STAT, s); chk("R11 status read clears", s, exp_stat(0, 1, 1, 0));

        // R7 random loopback with the pin held low
        rxd = 1'b0;
        wr(A_CTRL, 16'h0020);
        viol = 0;
        for (int i = 0; i < 12; i++) begin
            dv = $urandom_range(0, 3); bp = bit_clks(dv);
            exp_b = 8'($urandom);
            wr(A_DIV, 16'(dv));
            wr(A_TXH, {8'h00, exp_b});
            got = 1'b0;
            for (int c = 0; c < 12 * bp && !got; c++) begin
                @(negedge clk);
                if (txd !== 1'b1) viol++;
                peek_now(A_STAT, s);
                if (s[0]) got = 1'b1;
            end
            rd(A_RXB, r); chk("R7 loopback byte", r, exp_b);
        end
        chk("R7 txd held high", viol, 0);
        rxd = 1'b1;
        repeat (4) @(negedge clk);
        wr(A_CTRL, 16'h0000);

        // R8 break
        wr(A_CTRL, 16'h0010);
        repeat (5) @(negedge clk); chk("R8 break low", txd, 0);
        wr(A_CTRL, 16'h0000);
        repeat (2) @(negedge clk); chk("R8 break released", txd, 1);

        // R9 external source, divisor 0, 7 clk per tick
        bp = 112;
        wr(A_DIV, 16'h0000);
        wr(A_CTRL, 16'h0400);
        repeat (20) @(negedge clk);
        send_pin(8'hC3, bp, 1'b1);
        rd(A_RXB, r); chk("R9 ext rx byte", r, 8'hC3);
        wr(A_TXH, 16'h005A);
        tx_cap(bp, b1, hi, stp);
        chk("R9 ext tx byte", b1, 8'h5A);
        repeat (bp) @(negedge clk);

        // R10 interrupts
        dv = 1; bp = bit_clks(dv);
        wr(A_DIV, 16'(dv));
        wr(A_CTRL, 16'h0005);
        cnt = 0; fin = 1'b0;
        fork
            begin send_pin(8'h81, bp, 1'b1); fin = 1'b1; end
            while (!fin) begin @(negedge clk); if (irq_rx) cnt++; end
        join
        chk("R10 rx pulse count", cnt, 1);
        rd(A_RXB, r);
        cnt = 0;
        fork
            wr(A_TXH, 16'h0011);
            for (int c = 0; c < 11 * bp; c++) begin @(negedge clk); if (irq_tx) cnt++; end
        join
        chk("R10 tx pulse count", cnt, 1);
        wr(A_CTRL, 16'h0305);
        send_pin(8'h42, bp, 1'b1);
        chk("R10 rx level high", irq_rx, 1);
        chk("R10 tx level idle", irq_tx, 1);
        rd(A_RXB, r);
        chk("R10 rx level drops", irq_rx, 0);
        wr(A_TXH, 16'h0077);
        chk("R10 tx level drops", irq_tx, 0);
        repeat (11 * bp) @(negedge clk);
        wr(A_CTRL, 16'h0300);
        send_pin(8'h18, bp, 1'b1);
        chk("R10 disabled mode", irq_rx, 0);
        rd(A_RXB, r);

        // R11 framing error raises the receive interrupt when enabled
        wr(A_CTRL, 16'h0141);
        send_pin(8'hF0, bp, 1'b0);
        chk("R11 error irq", irq_rx, 1);
        rd(A_STAT, r);
        chk("R11 error irq cleared", irq_rx, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule